// File: doc/BRIEF.md
# Software Interrupt Broadcast Unit

This block turns a single 32-bit register write into one or more per-processor requests to mark a software interrupt as pending. A processor writes a word into a fixed command register. The word carries the interrupt number and a two-bit selector that says how the destination set is formed. The selector can pick an explicit list of processors, every processor but the writer, the writer alone, or (for the reserved code) everyone.

The writer's own index comes in on a separate input alongside the write. The block answers with a vector of one-cycle strobes, one bit per implemented processor, together with the interrupt number. The downstream pending bank sets its bits from these strobes, and the priority arbiter then re-evaluates its outputs. All outputs are registered, so they appear on the cycle after the write.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, `set_pend` is all zeros and `set_id` is zero.
- R2: Only a write with `wr_en` high, `wr_addr` equal to 0xF00 and all four bits of `wr_be` set has any effect. Any other address, or a partial byte-enable pattern, leaves `set_pend` at zero and `set_id` unchanged.
- R3: An accepted write raises `set_pend` on the clock edge that follows it, for exactly one cycle when no further accepted write follows.
- R4: `set_id` presents bits 9:0 of the accepted word in the same cycle as the strobes, and holds that value until the next accepted write.
- R5: When the selector (bits 25:24) is 0, the targets are bits 23:16 of the word, with bit 16+n meaning processor n, masked to the implemented processors.
- R6: When the selector is 1, the targets are every implemented processor except the one named by `req_cpu`.
- R7: When the selector is 2, the only target is the processor named by `req_cpu`.
- R8: When the selector is 3 (reserved), every implemented processor is targeted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (12) | Byte offset of the write |
| wr_be | input | 4 | Byte enables; all four must be set |
| wr_data | input | 32 | Written word |
| req_cpu | input | CPU_W (2) | Index of the processor issuing the write |
| set_pend | output | NUM_CPU (4) | One-cycle pending-set strobe per processor |
| set_id | output | ID_W (10) | Interrupt number that goes with the strobes |

## Verification
Every result is due exactly one cycle after the write: the write is presented on a falling edge and captured on the next rising edge. The bench reads `set_pend` and `set_id` on the falling edge that follows, then drops the write and reads again one cycle later to confirm that the strobe has returned to zero. The sweep covers all four selector codes against every requester index and several processor lists. Rejected writes are checked over the same two sampling points.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   // Field positions in the command word
   localparam int ID_LSB   = 0;
   localparam int LIST_LSB = 16;
   localparam int FILT_LSB = 24;

   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_ALL    = 2'd3
   } sgi_filter_e;
endpackage

// File: rtl/sgi_wr_decode.sv
module sgi_wr_decode #(
   parameter int ADDR_W  = 12,
   parameter logic [ADDR_W-1:0] REG_OFS = 12'hF00
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [3:0]        wr_be,
   output logic              hit
);
   // A full-word write to the command register is the only accepted form
   assign hit = wr_en && (wr_addr == REG_OFS) && (&wr_be);
endmodule

// File: rtl/sgi_target_sel.sv
module sgi_target_sel
   import sgi_pkg::*;
#(
   parameter int NUM_CPU = 4,
   localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  sgi_filter_e        filt,
   input  logic [NUM_CPU-1:0] list,
   input  logic [CPU_W-1:0]   req_cpu,
   output logic [NUM_CPU-1:0] targets
);
   localparam logic [NUM_CPU-1:0] ALL_MASK = {NUM_CPU{1'b1}};

   logic [NUM_CPU-1:0] self_vec;

   genvar g;
   generate
      if (NUM_CPU == 1) begin : g_single
         assign self_vec = 1'b1;
      end else begin : g_multi
         for (g = 0; g < NUM_CPU; g++) begin : g_self
            assign self_vec[g] = (req_cpu == CPU_W'(g));
         end
      end
   endgenerate

   always_comb begin
      unique case (filt)
         FLT_LIST:   targets = list;
         FLT_OTHERS: targets = ALL_MASK & ~self_vec;
         FLT_SELF:   targets = self_vec;
         default:    targets = ALL_MASK;
      endcase
   end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 12,
   parameter int ID_W    = 10,
   parameter logic [ADDR_W-1:0] REG_OFS = 12'hF00,
   localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [3:0]         wr_be,
   input  logic [31:0]        wr_data,
   input  logic [CPU_W-1:0]   req_cpu,
   output logic [NUM_CPU-1:0] set_pend,
   output logic [ID_W-1:0]    set_id
);
   generate
      if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
         $error("sgi_dispatch: NUM_CPU must lie in 1..8");
      end
      if (ID_W < 1 || ID_W > 10) begin : g_bad_id
         $error("sgi_dispatch: ID_W must lie in 1..10");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("sgi_dispatch: ADDR_W must be at least 12");
      end
   endgenerate

   logic               hit;
   logic [NUM_CPU-1:0] targets;
   sgi_filter_e        filt;
   logic               unused_bits;

   assign filt        = sgi_filter_e'(wr_data[FILT_LSB +: 2]);
   assign unused_bits = ^{wr_data[31:FILT_LSB+2], wr_data[FILT_LSB-1:LIST_LSB+NUM_CPU],
                          wr_data[LIST_LSB-1:ID_LSB+ID_W]};

   sgi_wr_decode #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_be   (wr_be),
      .hit     (hit)
   );

   sgi_target_sel #(.NUM_CPU(NUM_CPU)) u_sel (
      .filt    (filt),
      .list    (wr_data[LIST_LSB +: NUM_CPU]),
      .req_cpu (req_cpu),
      .targets (targets)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_pend <= '0;
         set_id   <= '0;
      end else begin
         set_pend <= hit ? targets : '0;
         if (hit) set_id <= wr_data[ID_LSB +: ID_W];
      end
   end

   // R2: rejected writes produce no strobe
   p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == REG_OFS && wr_be == 4'hF) |=> (set_pend == '0));
   // R4: number follows the accepted word
   p_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_OFS && wr_be == 4'hF) |=> (set_id == $past(wr_data[ID_W-1:0])));
   // R5: list mode never targets a processor outside the list
   p_list_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_OFS && wr_be == 4'hF && wr_data[25:24] == 2'd0)
      |=> ((set_pend & ~$past(wr_data[LIST_LSB +: NUM_CPU])) == '0));
   // R6: writer excluded
   p_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_OFS && wr_be == 4'hF && wr_data[25:24] == 2'd1)
      |=> !set_pend[$past(req_cpu)]);
   // R7: at most the writer
   p_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_OFS && wr_be == 4'hF && wr_data[25:24] == 2'd2)
      |=> $onehot0(set_pend));
   // R8: reserved code reaches everyone
   p_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_OFS && wr_be == 4'hF && wr_data[25:24] == 2'd3)
      |=> (set_pend == {NUM_CPU{1'b1}}));
endmodule

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
   localparam int NUM_CPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  req_cpu = '0;
   logic [3:0]  set_pend;
   logic [9:0]  set_id;

   int errors = 0;
   int checks = 0;
   logic [9:0] last_id = '0;

   always #5 clk = ~clk;

   sgi_dispatch #(.NUM_CPU(NUM_CPU)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
      .wr_data(wr_data), .req_cpu(req_cpu), .set_pend(set_pend), .set_id(set_id)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] expect_mask(input logic [1:0] f, input logic [3:0] lst,
                                              input int r);
      case (f)
         2'd0: return lst;
         2'd1: return 4'hF & ~(4'(1) << r);
         2'd2: return 4'(1) << r;
         default: return 4'hF;
      endcase
   endfunction

   task automatic do_write(input logic [11:0] a, input logic [3:0] be, input int r,
                           input logic [31:0] d, input logic [3:0] exp_mask,
                           input logic accept, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; req_cpu = 2'(r);
      @(negedge clk);
      wr_en = 1'b0;
      if (accept) last_id = d[9:0];
      check(req, 32'(set_pend), 32'(accept ? exp_mask : 4'h0));
      check("R4", 32'(set_id), 32'(last_id));
      @(negedge clk);
      check("R3", 32'(set_pend), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 32'(set_pend), 32'h0);
      check("R1", 32'(set_id), 32'h0);
      rst_n = 1'b1;
      for (int f = 0; f < 4; f++) begin
         for (int r = 0; r < NUM_CPU; r++) begin
            for (int l = 0; l < 16; l += 5) begin
               logic [31:0] d;
               string tag;
               d = (32'(f) << 24) | (32'(l) << 16) | 32'(((f * 97 + r * 31 + l * 7) % 1024));
               if (l == 10) d = d | 32'h00F0_0000;   // bits outside the implemented list
               tag = (f == 0) ? "R5" : (f == 1) ? "R6" : (f == 2) ? "R7" : "R8";
               do_write(12'hF00, 4'hF, r, d, expect_mask(2'(f), 4'(l), r), 1'b1, tag);
            end
         end
      end
      // R2: rejected forms
      do_write(12'hF04, 4'hF, 1, 32'h0300_0123, 4'h0, 1'b0, "R2");
      do_write(12'hF00, 4'h3, 2, 32'h0300_0155, 4'h0, 1'b0, "R2");
      do_write(12'hF00, 4'hE, 0, 32'h0300_0166, 4'h0, 1'b0, "R2");
      do_write(12'h700, 4'hF, 3, 32'h030F_0177, 4'h0, 1'b0, "R2");
      // R3: back-to-back writes then one-cycle release
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'hF00; wr_be = 4'hF; req_cpu = 2'd1; wr_data = 32'h0200_03FF;
      @(negedge clk);
      check("R7", 32'(set_pend), 32'h2);
      wr_data = 32'h0100_0001;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6", 32'(set_pend), 32'hD);
      check("R4", 32'(set_id), 32'h001);
      @(negedge clk);
      check("R3", 32'(set_pend), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule